// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block is a clocked front end for an asynchronous static RAM that is 16 bits wide and has separate enables for its upper and lower byte. A client offers one access at a time on a valid/ready handshake. Each access carries an address, a write word, a two-bit lane mask and a direction flag. Reads come back as a one-clock response strobe with the captured word. On the memory side the block drives the active-low chip, output and write enables, the two active-low byte enables and the address. It also drives a shared data bus through a tri-state control.

All memory timing is met by counting clocks. The nanosecond limits are parameters. Each limit becomes a cycle count by rounding the limit divided by the clock period up to a whole number, with a minimum of one cycle. A write is the window in which chip enable, write enable and the chosen byte enables are all low together. It lasts long enough to cover the write pulse width, the data set-up and the address-valid time. A read keeps output enable low for long enough to cover both the read cycle time and the output-enable-to-data time. The block only drives the data bus after the memory has had its release time since output enable last went high.

Every memory control line comes straight from a flop, so that no decode glitch reaches the memory's asynchronous enables.

Top module: `sramLaneCtrl`

## Requirements
- R1: While reset is held, and in the cycle after it, the chip, output, write, upper-byte and lower-byte enables are all high and the tri-state control is low. After reset the block shows ready high and the response strobe low. An access interrupted by reset never pulls write enable low.
- R2: A write with a non-zero mask drives chip enable, write enable and the selected byte enables low together for WP_CYC cycles, with the write word on the bus. WP_CYC is the largest of the rounded pulse-width, data set-up and address-valid limits, which is 1 with the default 8 ns clock. Mask bit 1 selects the upper byte (bus bits 15:8) and mask bit 0 selects the lower byte (bits 7:0). Only the selected bytes of the memory word change.
- R3: A write with mask 00 completes and returns ready without write enable ever going low, and leaves the memory word unchanged.
- R4: Write enable is high whenever output enable is low. A read keeps output enable low for RD_CYC cycles, the larger of the rounded read-cycle and output-to-data limits (2 by default). The response strobe rises on the RD_CYC-th clock edge after the accepting edge, lasts one cycle, and carries the word sampled at that edge.
- R5: A read enables only the byte lanes in its mask (bit 1 for the upper byte, bit 0 for the lower byte). Lanes that are not enabled return zero in the response word.
- R6: The tri-state control is high only while write enable is low. It is never high while output enable is low. It is low in the cycle before output enable falls.
- R7: The tri-state control is not raised until output enable has been high for at least HZ_CYC cycles, the rounded bus-release limit (1 by default).
- R8: Ready is low from the accepting edge until the access is complete. It is low in every cycle in which the response strobe is high.
- R9: The address bus holds still for as long as chip enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | An access is offered |
| reqReady | output | 1 | The block can accept an access |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | 16 | Write word |
| reqMask | input | 2 | Lane mask: bit 1 is the upper byte, bit 0 is the lower byte |
| rspValid | output | 1 | One-cycle strobe for read data |
| rspData | output | 16 | Captured read word, with unselected lanes set to zero |
| sramCeN | output | 1 | Chip enable, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramUbN | output | 1 | Upper byte enable, active low |
| sramLbN | output | 1 | Lower byte enable, active low |
| sramAddr | output | ADDR_W | Memory address |
| sramDq | inout | 16 | Shared data bus |
| sramDqOe | output | 1 | High while the block drives sramDq |

## Verification
On every cycle the assertions check the safety rules between the pins. Write enable never falls while output enable is low, and it only falls together with chip enable, a byte enable and the bus drive. Bus drive never overlaps output enable, never starts too soon after output enable rises, and is off in the cycle before output enable falls. The address holds while chip enable is low, the response strobe lasts one cycle, and ready stays low during it. Only the bench scenarios can show that the right bytes reach the memory array for each mask, and that a zero-mask write leaves memory untouched. They also show that masked read lanes come back as zero, that the response arrives at the computed latency, and that reset in the middle of an access stops it before any write.

// File: rtl/sramLanePkg.sv
package sramLanePkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WGAP,
    ST_WPULSE,
    ST_WREL,
    ST_RACT,
    ST_RDONE
  } state_t;

  // Strobes from control to datapath, describing the coming cycle.
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic lanesOn;
    logic drive;
    logic load;
    logic capture;
  } strobe_t;

  function automatic int unsigned nsToCyc(int unsigned ns, int unsigned clkNs);
    int unsigned c;
    c = (ns + clkNs - 1) / clkNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned maxOf(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramLaneFsm.sv
module sramLaneFsm
  import sramLanePkg::*;
#(
  parameter int unsigned HZ_CYC = 1,
  parameter int unsigned WP_CYC = 1,
  parameter int unsigned RD_CYC = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    maskZero,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int unsigned MAX_CYC = maxOf(maxOf(HZ_CYC, WP_CYC), RD_CYC);
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  localparam logic [CNT_W-1:0] HZ_LAST = CNT_W'(HZ_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);

  state_t state, nextState;
  logic [CNT_W-1:0] cnt;
  logic cntLast;
  logic accept;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqReady && reqValid;

  always_comb begin
    case (state)
      ST_WGAP:   cntLast = (cnt == HZ_LAST);
      ST_WPULSE: cntLast = (cnt == WP_LAST);
      ST_RACT:   cntLast = (cnt == RD_LAST);
      default:   cntLast = 1'b1;
    endcase
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          if (!reqWrite)    nextState = ST_RACT;
          else if (maskZero) nextState = ST_WREL;
          else              nextState = ST_WGAP;
        end
      end
      ST_WGAP:   if (cntLast) nextState = ST_WPULSE;
      ST_WPULSE: if (cntLast) nextState = ST_WREL;
      ST_WREL:   nextState = ST_IDLE;
      ST_RACT:   if (cntLast) nextState = ST_RDONE;
      ST_RDONE:  nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (nextState != state) cnt <= '0;
      else if (!cntLast)      cnt <= cnt + 1'b1;
    end
  end

  // Pins follow the next state, so the pin flops line up with the state flops.
  always_comb begin
    strb.ceN     = !(nextState == ST_WGAP || nextState == ST_WPULSE || nextState == ST_RACT);
    strb.oeN     = !(nextState == ST_RACT);
    strb.weN     = !(nextState == ST_WPULSE);
    strb.lanesOn = (nextState == ST_WPULSE) || (nextState == ST_RACT);
    strb.drive   = (nextState == ST_WPULSE);
    strb.load    = accept;
    strb.capture = (state == ST_RACT) && cntLast;
  end

endmodule

// File: rtl/sramLaneData.sv
module sramLaneData
  import sramLanePkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned LANES  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobe_t               strb,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [8*LANES-1:0]    reqWdata,
  input  logic [LANES-1:0]      reqMask,
  input  logic [8*LANES-1:0]    dqIn,
  output logic                  ceN,
  output logic                  oeN,
  output logic                  weN,
  output logic [LANES-1:0]      beN,
  output logic [ADDR_W-1:0]     addr,
  output logic [8*LANES-1:0]    dqOut,
  output logic                  dqOe,
  output logic [8*LANES-1:0]    rspData,
  output logic                  rspValid
);

  localparam int unsigned DATA_W = 8 * LANES;

  logic [LANES-1:0] maskReg;
  logic [LANES-1:0] maskSel;

  assign maskSel = strb.load ? reqMask : maskReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      ceN      <= 1'b1;
      oeN      <= 1'b1;
      weN      <= 1'b1;
      beN      <= '1;
      dqOe     <= 1'b0;
      rspValid <= 1'b0;
      maskReg  <= '0;
      addr     <= '0;
      dqOut    <= '0;
    end else begin
      ceN      <= strb.ceN;
      oeN      <= strb.oeN;
      weN      <= strb.weN;
      beN      <= strb.lanesOn ? ~maskSel : '1;
      dqOe     <= strb.drive;
      rspValid <= strb.capture;
      if (strb.load) begin
        maskReg <= reqMask;
        addr    <= reqAddr;
        dqOut   <= reqWdata;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (rst)
        rspData[8*g +: 8] <= 8'h00;
      else if (strb.capture)
        rspData[8*g +: 8] <= maskReg[g] ? dqIn[8*g +: 8] : 8'h00;
    end
  end

  logic unusedW;
  assign unusedW = ^DATA_W;

endmodule

// File: rtl/sramLaneCtrl.sv
module sramLaneCtrl
  import sramLanePkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned CLK_NS   = 8,
  parameter int unsigned T_HZ_NS  = 6,
  parameter int unsigned T_WP_NS  = 8,
  parameter int unsigned T_SD_NS  = 6,
  parameter int unsigned T_AW_NS  = 8,
  parameter int unsigned T_RC_NS  = 12,
  parameter int unsigned T_DOE_NS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        reqMask,
  output logic              rspValid,
  output logic [15:0]       rspData,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic              sramUbN,
  output logic              sramLbN,
  output logic [ADDR_W-1:0] sramAddr,
  inout  wire  [15:0]       sramDq,
  output logic              sramDqOe
);

  localparam int unsigned LANES  = 2;
  localparam int unsigned HZ_CYC = nsToCyc(T_HZ_NS, CLK_NS);
  localparam int unsigned WP_CYC = maxOf(maxOf(nsToCyc(T_WP_NS, CLK_NS),
                                               nsToCyc(T_SD_NS, CLK_NS)),
                                         nsToCyc(T_AW_NS, CLK_NS));
  localparam int unsigned RD_CYC = maxOf(nsToCyc(T_RC_NS, CLK_NS),
                                         nsToCyc(T_DOE_NS, CLK_NS));

  strobe_t strb;
  logic [LANES-1:0] beN;
  logic [15:0] dqOut;

  sramLaneFsm #(
    .HZ_CYC(HZ_CYC),
    .WP_CYC(WP_CYC),
    .RD_CYC(RD_CYC)
  ) u_fsm (
    .clk(clk),
    .rst(rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .maskZero(reqMask == 2'b00),
    .reqReady(reqReady),
    .strb(strb)
  );

  sramLaneData #(
    .ADDR_W(ADDR_W),
    .LANES(LANES)
  ) u_data (
    .clk(clk),
    .rst(rst),
    .strb(strb),
    .reqAddr(reqAddr),
    .reqWdata(reqWdata),
    .reqMask(reqMask),
    .dqIn(sramDq),
    .ceN(sramCeN),
    .oeN(sramOeN),
    .weN(sramWeN),
    .beN(beN),
    .addr(sramAddr),
    .dqOut(dqOut),
    .dqOe(sramDqOe),
    .rspData(rspData),
    .rspValid(rspValid)
  );

  assign sramUbN = beN[1];
  assign sramLbN = beN[0];
  assign sramDq  = sramDqOe ? dqOut : 16'hzzzz;

endmodule

// File: rtl/sramLaneChk.sv
module sramLaneChk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned HZ_CYC = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              rspValid,
  input logic              sramCeN,
  input logic              sramOeN,
  input logic              sramWeN,
  input logic              sramUbN,
  input logic              sramLbN,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramDqOe
);

  localparam int unsigned HC_W = $clog2(HZ_CYC + 2);
  localparam logic [HC_W-1:0] HC_MAX = HC_W'(HZ_CYC + 1);

  logic [HC_W-1:0] oeHighCnt;

  always_ff @(posedge clk) begin
    if (rst)            oeHighCnt <= HC_MAX;
    else if (!sramOeN)  oeHighCnt <= '0;
    else if (oeHighCnt != HC_MAX) oeHighCnt <= oeHighCnt + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (sramCeN && sramOeN && sramWeN && sramUbN && sramLbN && !sramDqOe));

  p_write_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    !sramWeN |-> (!sramCeN && (!sramUbN || !sramLbN) && sramDqOe));

  p_we_in_read_r4: assert property (@(posedge clk) disable iff (rst)
    !sramOeN |-> sramWeN);

  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid);

  p_drive_only_write_r6: assert property (@(posedge clk) disable iff (rst)
    sramDqOe |-> (sramOeN && !sramWeN));

  p_drive_gap_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(sramOeN) |-> !$past(sramDqOe));

  p_release_wait_r7: assert property (@(posedge clk) disable iff (rst)
    sramDqOe |-> (oeHighCnt >= HC_W'(HZ_CYC)));

  p_busy_no_ready_r8: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> !reqReady);

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr));

endmodule

bind sramLaneCtrl sramLaneChk #(
  .ADDR_W(ADDR_W),
  .HZ_CYC(HZ_CYC)
) u_chk (
  .clk(clk),
  .rst(rst),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .sramCeN(sramCeN),
  .sramOeN(sramOeN),
  .sramWeN(sramWeN),
  .sramUbN(sramUbN),
  .sramLbN(sramLbN),
  .sramAddr(sramAddr),
  .sramDqOe(sramDqOe)
);

// File: tb/sramLaneCtrl_bench.sv
module sramLaneCtrl_bench;

  localparam int AW      = 8;
  localparam int RD_LAT  = 3;   // accept edge + ceil(12/8)=2 read cycles
  localparam int WP_EXP  = 1;   // ceil(8/8)
  localparam int HZ_EXP  = 1;   // ceil(6/8)

  // {write, mask[1:0], addr[7:0], data[15:0], expected[15:0]}
  localparam int NV = 13;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 2'b11, 8'h10, 16'hA55A, 16'hA55A},
    {1'b0, 2'b11, 8'h10, 16'h0000, 16'hA55A},
    {1'b1, 2'b10, 8'h10, 16'h1234, 16'h125A},
    {1'b0, 2'b11, 8'h10, 16'h0000, 16'h125A},
    {1'b1, 2'b01, 8'h10, 16'hFFCD, 16'h12CD},
    {1'b0, 2'b11, 8'h10, 16'h0000, 16'h12CD},
    {1'b0, 2'b10, 8'h10, 16'h0000, 16'h1200},
    {1'b0, 2'b01, 8'h10, 16'h0000, 16'h00CD},
    {1'b1, 2'b00, 8'h20, 16'hBEEF, 16'h0000},
    {1'b0, 2'b11, 8'h20, 16'h0000, 16'h0000},
    {1'b1, 2'b11, 8'h21, 16'hFFFF, 16'hFFFF},
    {1'b0, 2'b11, 8'h21, 16'h0000, 16'hFFFF},
    {1'b0, 2'b11, 8'h20, 16'h0000, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0] reqMask = '0;
  logic reqReady, rspValid;
  logic [15:0] rspData;
  logic sramCeN, sramOeN, sramWeN, sramUbN, sramLbN, sramDqOe;
  logic [AW-1:0] sramAddr;
  wire  [15:0] sramDq;

  always #4 clk = ~clk;

  sramLaneCtrl #(.ADDR_W(AW)) u_sramLaneCtrl (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspData(rspData),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .sramUbN(sramUbN), .sramLbN(sramLbN), .sramAddr(sramAddr),
    .sramDq(sramDq), .sramDqOe(sramDqOe)
  );

  // Memory model
  logic [15:0] mem [256];
  logic memDrive;
  assign memDrive = !sramCeN && !sramOeN && sramWeN;
  assign sramDq[15:8] = (memDrive && !sramUbN) ? mem[sramAddr][15:8] : 8'hzz;
  assign sramDq[7:0]  = (memDrive && !sramLbN) ? mem[sramAddr][7:0]  : 8'hzz;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;
  int weLow = 0;
  int errR2 = 0, errR4 = 0, errR6 = 0, errR7 = 0, errR9 = 0;
  int oeHigh = 100;
  logic [1:0] curMask = '0;
  logic prevCeN = 1'b1;
  logic [AW-1:0] prevAddr = '0;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

  always @(negedge clk) begin
    if (!rst) begin
      if (!sramCeN && !sramWeN) begin
        if (!sramUbN) mem[sramAddr][15:8] = sramDq[15:8];
        if (!sramLbN) mem[sramAddr][7:0]  = sramDq[7:0];
      end
      if (!sramWeN) begin
        weLow++;
        if ({sramUbN, sramLbN} != ~curMask) errR2++;
        if (sramCeN || !sramDqOe) errR2++;
      end
      if (!sramOeN && !sramWeN) errR4++;
      if (sramDqOe && (memDrive || !sramOeN)) errR6++;
      if (sramDqOe && oeHigh < HZ_EXP) errR7++;
      if (!sramCeN && !prevCeN && sramAddr != prevAddr) errR9++;
      if (!sramOeN) oeHigh = 0;
      else if (oeHigh < 100) oeHigh++;
      prevCeN = sramCeN;
      prevAddr = sramAddr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runTxn(input logic wr, input logic [1:0] mask, input logic [AW-1:0] a,
                        input logic [15:0] d, input logic [15:0] exp);
    int lat;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqMask = mask; reqAddr = a; reqWdata = d;
    curMask = mask;
    weLow = 0;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R8 ready low after accept", 32'(reqReady), 32'd0);
    if (!wr) begin
      lat = 1;
      while (!rspValid && lat < 20) begin @(negedge clk); lat++; end
      chk(lat == RD_LAT, "R4 read latency", 32'(lat), 32'(RD_LAT));
      chk(rspData == exp, (mask == 2'b11) ? "R4 read data" : "R5 masked read data",
          32'(rspData), 32'(exp));
      chk(!reqReady, "R8 ready low with response", 32'(reqReady), 32'd0);
      @(negedge clk);
      chk(!rspValid, "R4 response one cycle", 32'(rspValid), 32'd0);
    end else begin
      while (!reqReady) @(negedge clk);
      chk(mem[a] == exp, (mask == 2'b00) ? "R3 memory after empty write" : "R2 memory after write",
          32'(mem[a]), 32'(exp));
      chk(weLow == ((mask == 2'b00) ? 0 : WP_EXP),
          (mask == 2'b00) ? "R3 write enable cycles" : "R2 write enable cycles",
          32'(weLow), 32'((mask == 2'b00) ? 0 : WP_EXP));
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle pins while in reset
    chk({sramCeN, sramOeN, sramWeN, sramUbN, sramLbN, sramDqOe} == 6'b111110,
        "R1 pins in reset", 32'({sramCeN, sramOeN, sramWeN, sramUbN, sramLbN, sramDqOe}), 32'h3E);
    rst = 1'b0;
    @(negedge clk);
    chk(reqReady && !rspValid, "R1 ready after reset", 32'({reqReady, rspValid}), 32'h2);

    for (int i = 0; i < NV; i++)
      runTxn(VEC[i][42], VEC[i][41:40], VEC[i][39:32], VEC[i][31:16], VEC[i][15:0]);

    // Reset in the middle of a write (R1)
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqMask = 2'b11; reqAddr = 8'h30; reqWdata = 16'hC0DE;
    curMask = 2'b11; weLow = 0;
    @(negedge clk);
    reqValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk({sramCeN, sramOeN, sramWeN, sramUbN, sramLbN, sramDqOe} == 6'b111110,
        "R1 pins after mid-write reset",
        32'({sramCeN, sramOeN, sramWeN, sramUbN, sramLbN, sramDqOe}), 32'h3E);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(mem[8'h30] == 16'h0000 && weLow == 0, "R1 aborted write left memory",
        32'(mem[8'h30]), 32'h0);
    chk(reqReady, "R1 ready after mid-write reset", 32'(reqReady), 32'd1);

    // Read right after a write, then write right after a read: turnaround
    runTxn(1'b1, 2'b11, 8'h40, 16'h5AA5, 16'h5AA5);
    runTxn(1'b0, 2'b11, 8'h40, 16'h0000, 16'h5AA5);
    runTxn(1'b1, 2'b01, 8'h40, 16'h0011, 16'h5A11);

    chk(errR2 == 0, "R2 write overlap and byte enables", 32'(errR2), 32'd0);
    chk(errR4 == 0, "R4 write enable high in reads", 32'(errR4), 32'd0);
    chk(errR6 == 0, "R6 no bus contention", 32'(errR6), 32'd0);
    chk(errR7 == 0, "R7 release wait before drive", 32'(errR7), 32'd0);
    chk(errR9 == 0, "R9 address stable while selected", 32'(errR9), 32'd0);
    finish();
  end

endmodule